// File: doc/BRIEF.md
# Saturating Two-Stream PCM Mixer

This block combines two signed PCM sample streams into one stream for a serial codec transmitter. The primary samples come from the first transmit FIFO and the secondary samples from a separate secondary FIFO. Both FIFOs show their head word while not empty, and the mixer pops that word. Both sources must share one sampling rate and one PCM format, so the block does no rate or format conversion.

On each sample request the block pops one word from each FIFO that holds data. It sign-extends both words according to a software-selected bit length and adds them with one bit of headroom. It then clamps the sum to the range of that bit length, and the result appears one cycle later. Successive requests serve the left channel first and then the right channel. A FIFO that has run dry contributes zero, so the other stream passes through unchanged.

Top module: `pcm_sat_mixer`

## Requirements
- R1: While reset is held and after it is released, `mix_valid`, `mix_right` and `mix_data` are all zero until the first request.
- R2: `pri_pop` equals `smp_req` AND NOT `pri_empty`, and `sec_pop` equals `smp_req` AND NOT `sec_empty`, in the same cycle. There is no pop without a request.
- R3: `mix_valid` is high in the cycle after a request and low in the cycle after a cycle with no request.
- R4: The first output after reset is the left channel (`mix_right` = 0). Each later request alternates the channel (1 = right).
- R5: `bit_len` code 0 selects 8-bit, code 1 selects 16-bit and code 2 selects 24-bit samples. Samples sit in the low bits of the 24-bit data word, and bits above the selected length are ignored.
- R6: `bit_len` code 3 behaves as code 2 (24-bit).
- R7: When the signed sum fits the selected length, `mix_data` is exactly that sum, sign-extended to the full 24 bits.
- R8: A sum above the largest positive value of the selected length yields that value. A sum below the most negative value yields the most negative value.
- R9: If the secondary FIFO is empty at a request, the output is the primary sample unchanged.
- R10: If the primary FIFO is empty at a request, the primary contribution is zero.
- R11: Between requests, `mix_data` and `mix_right` hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_len | input | 2 | Sample length code (0: 8, 1: 16, 2/3: 24 bits) |
| smp_req | input | 1 | Output sample request from the transmitter |
| pri_empty | input | 1 | Primary FIFO empty |
| pri_data | input | 24 | Primary FIFO head word |
| pri_pop | output | 1 | Pop the primary FIFO |
| sec_empty | input | 1 | Secondary FIFO empty |
| sec_data | input | 24 | Secondary FIFO head word |
| sec_pop | output | 1 | Pop the secondary FIFO |
| mix_valid | output | 1 | Mixed sample valid |
| mix_right | output | 1 | Channel of the mixed sample (1 = right) |
| mix_data | output | 24 | Mixed, saturated sample, sign-extended |

## Verification
Two things can happen on the same request: clamping of an overflowing sum, and substitution of zero for a source that has run dry. The bench provokes both together by driving full-scale primary values, including the extremes, while the secondary FIFO reports empty, and the reverse. A correct result is the untouched surviving sample, with no clamp artefact. The bench also crosses overflow with the channel alternation, using a 16-by-16 value grid per length code, so that saturated results land on both left and right slots. It compares each output against a sum that it computes and clamps arithmetically.

// File: rtl/mix_pkg.sv
package mix_pkg;
   typedef enum logic [1:0] {
      BLEN_8   = 2'd0,
      BLEN_16  = 2'd1,
      BLEN_24  = 2'd2,
      BLEN_RSV = 2'd3
   } blen_e;

   // reserved code folds onto the widest length
   function automatic logic [1:0] blen_index(input logic [1:0] code, input int num_len);
      if (int'(code) >= num_len) return 2'(num_len - 1);
      return code;
   endfunction
endpackage

// File: rtl/mix_sext.sv
module mix_sext #(
   parameter int BASE_W  = 8,
   parameter int NUM_LEN = 3
) (
   input  logic [BASE_W*NUM_LEN-1:0] raw_i,
   input  logic [1:0]                idx_i,
   output logic [BASE_W*NUM_LEN-1:0] ext_o
);
   localparam int SW = BASE_W * NUM_LEN;

   logic [SW-1:0] cand [NUM_LEN];

   for (genvar g = 0; g < NUM_LEN; g++) begin : g_len
      localparam int W = BASE_W * (g + 1);
      if (W == SW) begin : g_full
         assign cand[g] = raw_i;
      end else begin : g_part
         assign cand[g] = {{(SW-W){raw_i[W-1]}}, raw_i[W-1:0]};
      end
   end

   always_comb begin
      ext_o = cand[NUM_LEN-1];
      for (int k = 0; k < NUM_LEN; k++) begin
         if (idx_i == 2'(k)) ext_o = cand[k];
      end
   end
endmodule

// File: rtl/mix_sat_add.sv
module mix_sat_add #(
   parameter int BASE_W  = 8,
   parameter int NUM_LEN = 3
) (
   input  logic [BASE_W*NUM_LEN-1:0] a_i,
   input  logic [BASE_W*NUM_LEN-1:0] b_i,
   input  logic [1:0]                idx_i,
   output logic [BASE_W*NUM_LEN-1:0] sum_o
);
   localparam int SW = BASE_W * NUM_LEN;

   logic signed [SW:0] sum_wide;
   logic signed [SW:0] lim_hi [NUM_LEN];
   logic signed [SW:0] lim_lo [NUM_LEN];
   logic signed [SW:0] hi_sel;
   logic signed [SW:0] lo_sel;

   assign sum_wide = $signed({a_i[SW-1], a_i}) + $signed({b_i[SW-1], b_i});

   for (genvar g = 0; g < NUM_LEN; g++) begin : g_lim
      localparam int W = BASE_W * (g + 1);
      localparam logic signed [SW:0] ONE = 1;
      assign lim_hi[g] = (ONE <<< (W - 1)) - ONE;
      assign lim_lo[g] = -(ONE <<< (W - 1));
   end

   always_comb begin
      hi_sel = lim_hi[NUM_LEN-1];
      lo_sel = lim_lo[NUM_LEN-1];
      for (int k = 0; k < NUM_LEN; k++) begin
         if (idx_i == 2'(k)) begin
            hi_sel = lim_hi[k];
            lo_sel = lim_lo[k];
         end
      end
      if (sum_wide > hi_sel)      sum_o = hi_sel[SW-1:0];
      else if (sum_wide < lo_sel) sum_o = lo_sel[SW-1:0];
      else                        sum_o = sum_wide[SW-1:0];
   end
endmodule

// File: rtl/mix_chan_seq.sv
module mix_chan_seq (
   input  logic clk,
   input  logic rst_n,
   input  logic step_i,
   output logic right_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)      right_o <= 1'b0;
      else if (step_i) right_o <= ~right_o;
   end
endmodule

// File: rtl/pcm_sat_mixer.sv
module pcm_sat_mixer #(
   parameter int BASE_W  = 8,
   parameter int NUM_LEN = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [1:0]                bit_len,
   input  logic                      smp_req,
   input  logic                      pri_empty,
   input  logic [BASE_W*NUM_LEN-1:0] pri_data,
   output logic                      pri_pop,
   input  logic                      sec_empty,
   input  logic [BASE_W*NUM_LEN-1:0] sec_data,
   output logic                      sec_pop,
   output logic                      mix_valid,
   output logic                      mix_right,
   output logic [BASE_W*NUM_LEN-1:0] mix_data
);
   import mix_pkg::*;

   localparam int SW = BASE_W * NUM_LEN;

   initial begin
      if (BASE_W < 2)                    $error("BASE_W must be at least 2");
      if (NUM_LEN < 1 || NUM_LEN > 4)    $error("NUM_LEN must be 1..4 for a 2-bit length code");
   end

   logic [1:0]    len_idx;
   logic [SW-1:0] pri_ext, sec_ext;
   logic [SW-1:0] pri_eff, sec_eff;
   logic [SW-1:0] sat_sum;
   logic          chan_q;

   assign len_idx = blen_index(bit_len, NUM_LEN);
   assign pri_pop = smp_req & ~pri_empty;
   assign sec_pop = smp_req & ~sec_empty;

   mix_sext #(.BASE_W(BASE_W), .NUM_LEN(NUM_LEN)) u_pri_ext (
      .raw_i(pri_data), .idx_i(len_idx), .ext_o(pri_ext));
   mix_sext #(.BASE_W(BASE_W), .NUM_LEN(NUM_LEN)) u_sec_ext (
      .raw_i(sec_data), .idx_i(len_idx), .ext_o(sec_ext));

   // a dry source contributes silence
   assign pri_eff = pri_empty ? '0 : pri_ext;
   assign sec_eff = sec_empty ? '0 : sec_ext;

   mix_sat_add #(.BASE_W(BASE_W), .NUM_LEN(NUM_LEN)) u_add (
      .a_i(pri_eff), .b_i(sec_eff), .idx_i(len_idx), .sum_o(sat_sum));

   mix_chan_seq u_chan (.clk(clk), .rst_n(rst_n), .step_i(smp_req), .right_o(chan_q));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mix_valid <= 1'b0;
         mix_right <= 1'b0;
         mix_data  <= '0;
      end else begin
         mix_valid <= smp_req;
         if (smp_req) begin
            mix_data  <= sat_sum;
            mix_right <= chan_q;
         end
      end
   end

   AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      smp_req |=> mix_valid);                                        // R3
   AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_req |=> !mix_valid);                                      // R3
   AST_NO_POP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_req |-> !pri_pop && !sec_pop);                            // R2
   AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (pri_empty |-> !pri_pop) and (sec_empty |-> !sec_pop));        // R2
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_req |=> $stable(mix_data) && $stable(mix_right));         // R11
   AST_SHORT_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
      smp_req && bit_len == 2'd0 |=>
      (mix_data[SW-1:BASE_W-1] == '0 || mix_data[SW-1:BASE_W-1] == '1)); // R8
endmodule

// File: tb/tb_pcm_sat_mixer.sv
module tb_pcm_sat_mixer;
   localparam int SW = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    bit_len = 2'd0;
   logic          smp_req = 1'b0;
   logic          pri_empty = 1'b1, sec_empty = 1'b1;
   logic [SW-1:0] pri_data = '0, sec_data = '0;
   logic          pri_pop, sec_pop, mix_valid, mix_right;
   logic [SW-1:0] mix_data;

   int checks = 0;
   int failures = 0;
   bit exp_right = 1'b0;

   always #5 clk = ~clk;

   pcm_sat_mixer dut (
      .clk(clk), .rst_n(rst_n), .bit_len(bit_len), .smp_req(smp_req),
      .pri_empty(pri_empty), .pri_data(pri_data), .pri_pop(pri_pop),
      .sec_empty(sec_empty), .sec_data(sec_data), .sec_pop(sec_pop),
      .mix_valid(mix_valid), .mix_right(mix_right), .mix_data(mix_data));

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int len_of(input logic [1:0] code);
      return (code == 2'd3) ? 24 : 8 * (int'(code) + 1);
   endfunction

   function automatic longint sext(input logic [SW-1:0] raw, input int l);
      longint v = longint'(raw) & ((64'sd1 <<< l) - 1);
      if (v >= (64'sd1 <<< (l - 1))) v -= (64'sd1 <<< l);
      return v;
   endfunction

   function automatic logic [SW-1:0] expect_mix(input logic [SW-1:0] a, input logic [SW-1:0] b,
                                                input bit pe, input bit se, input logic [1:0] code);
      int l = len_of(code);
      longint s = (pe ? 0 : sext(a, l)) + (se ? 0 : sext(b, l));
      longint hi = (64'sd1 <<< (l - 1)) - 1;
      longint lo = -(64'sd1 <<< (l - 1));
      if (s > hi) s = hi;
      if (s < lo) s = lo;
      return SW'(s);
   endfunction

   // raw word: sample in the low bits, junk above the selected length (R5)
   function automatic logic [SW-1:0] pack(input longint v, input int l);
      logic [SW-1:0] m = (l == SW) ? '1 : SW'((64'sd1 <<< l) - 1);
      return (SW'(v) & m) | (24'hA5C3E1 & ~m);
   endfunction

   function automatic longint grid(input int i, input int l);
      return -(64'sd1 <<< (l - 1)) + (longint'(i) * ((64'sd1 <<< l) - 1)) / 15;
   endfunction

   task automatic one_req(input logic [SW-1:0] a, input logic [SW-1:0] b,
                          input bit pe, input bit se, input logic [1:0] code, input string tag);
      logic [SW-1:0] exp;
      @(negedge clk);
      bit_len = code; pri_data = a; sec_data = b; pri_empty = pe; sec_empty = se;
      smp_req = 1'b1;
      #1;
      check(pri_pop == !pe, "R2 pri_pop", pri_pop, !pe);
      check(sec_pop == !se, "R2 sec_pop", sec_pop, !se);
      exp = expect_mix(a, b, pe, se, code);
      @(negedge clk);
      smp_req = 1'b0;
      check(mix_valid == 1'b1, "R3 valid", mix_valid, 1);
      check(mix_right == exp_right, "R4 channel", mix_right, exp_right);
      check(mix_data == exp, tag, mix_data, exp);
      exp_right = !exp_right;
   endtask

   task automatic idle_check;
      logic [SW-1:0] d0;
      logic          r0;
      d0 = mix_data; r0 = mix_right;
      @(negedge clk);
      pri_empty = 1'b0; sec_empty = 1'b0; pri_data = ~d0; sec_data = 24'h123456;
      #1;
      check(!pri_pop && !sec_pop, "R2 no pop idle", {pri_pop, sec_pop}, 0);
      @(negedge clk);
      check(mix_valid == 1'b0, "R3 idle valid", mix_valid, 0);
      check(mix_data == d0 && mix_right == r0, "R11 hold", mix_data, d0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(mix_valid == 0 && mix_right == 0 && mix_data == 0, "R1 in reset", mix_data, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(mix_valid == 0 && mix_right == 0 && mix_data == 0, "R1 after reset", mix_data, 0);

      for (int code = 0; code < 4; code++) begin
         int l = len_of(2'(code));
         for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
               one_req(pack(grid(i, l), l), pack(grid(j, l), l), 1'b0, 1'b0, 2'(code),
                       (code == 3) ? "R6 code3 mix" : "R5 R7 R8 mix");
            end
         end
         for (int i = 0; i < 16; i++) begin
            one_req(pack(grid(i, l), l), pack(grid(15 - i, l), l), 1'b0, 1'b1, 2'(code), "R9 sec dry");
            one_req(pack(grid(15 - i, l), l), pack(grid(i, l), l), 1'b1, 1'b0, 2'(code), "R10 pri dry");
         end
         one_req(pack(grid(15, l), l), pack(grid(15, l), l), 1'b1, 1'b1, 2'(code), "R9 R10 both dry");
         idle_check();
      end
      // explicit extremes: 8-bit
      one_req(24'hFFFF7F, 24'h000001, 1'b0, 1'b0, 2'd0, "R8 pos clamp");
      one_req(24'h000080, 24'hFFFF80, 1'b0, 1'b0, 2'd0, "R8 neg clamp");
      one_req(24'h00007F, 24'h000080, 1'b0, 1'b0, 2'd0, "R7 in range");

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule